// File: doc/BRIEF.md
# Packed-Index Vector Table Lookup Expander

The block turns a stream of packed 4-bit indices into four byte vectors by looking each index up in a 512-bit table. The table is treated as sixteen 32-bit slots. Each index picks one slot, and the result byte is the low eight bits of that slot. The index operand is 2·VL bits wide and is formed from two source vectors, with the second one placed above the first. The table and the index operand are latched when an operation starts. The block then drives one destination vector per clock onto a register-file write port, for four clocks in a row.

The destination register numbers follow one of two patterns. In the grouped pattern the four registers are adjacent and start at a multiple of four. In the interleaved pattern they are spaced four apart, starting in register 0–3 or 16–19. The block also gives the pair of source register numbers that a two-register index operand would come from. A non-zero element-size field marks the operation as undefined. In that case the block raises a one-cycle flag and writes nothing.

Top module: `nibble_lut_expander`

## Requirements
- R1: Every output byte equals bits [32·k+7 : 32·k] of the table, where k is its 4-bit index. The upper 24 bits of each slot never reach the output.
- R2: The index operand is {hiSrc, loSrc}, read as 4-bit fields with field 0 at bit 0. Element e of result r (bits 8e+7:8e of wrData) uses field r·(VL/8)+e.
- R3: An accepted valid start produces exactly four writes (wrEn high), in the four cycles that follow the accepting edge. They come in the order r = 0, 1, 2, 3.
- R4: With `interleaved` = 0, write r targets register 4·grpSel + r.
- R5: With `interleaved` = 1, write r targets register {bankSel, 2'b00, laneSel} + 4·r.
- R6: srcRegLo = 2·srcSel and srcRegHi = 2·srcSel + 1, at all times.
- R7: An accepted start with sizeSel ≠ 2'b00 sets undefFlag for exactly the following cycle. It produces no write and leaves busy low.
- R8: done is high for exactly one cycle, the cycle right after the fourth write, and busy is low in that cycle.
- R9: busy is high during the four write cycles. A start while busy is ignored. Changing the index, table or mode inputs after the accepting edge has no effect on the writes.
- R10: While reset is held, wrEn, busy, done and undefFlag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an operation; accepted when not busy |
| sizeSel | input | 2 | Element-size field; only 2'b00 is valid |
| interleaved | input | 1 | 0: grouped destinations, 1: stride-4 destinations |
| grpSel | input | 3 | Destination group for the grouped pattern |
| bankSel | input | 1 | Upper/lower bank for the interleaved pattern |
| laneSel | input | 2 | Starting lane for the interleaved pattern |
| srcSel | input | 4 | Source pair selector |
| idxOperand | input | 2*VL | Packed 4-bit indices {hiSrc, loSrc} |
| tableIn | input | 512 | Sixteen 32-bit table slots |
| srcRegLo | output | 5 | Register number of the low index source |
| srcRegHi | output | 5 | Register number of the high index source |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| undefFlag | output | 1 | One-cycle undefined-encoding pulse |
| wrEn | output | 1 | Register-file write enable |
| wrReg | output | 5 | Destination register number |
| wrData | output | VL | Destination vector data |

## Verification
Some properties are checked on every cycle. Each run is exactly four writes long, and done follows straight after the last write and lasts one cycle. Successive destination numbers step by 1 or by 4, and an undefined-size request never overlaps a write. Other behaviour only shows in the bench's scenarios, where a behavioural model is compared each clock. That covers the byte values picked from the table, the field order across the four results, and the absolute register numbers in both patterns. It also covers whether operands changed during a run, or a start raised during a run, leave the results untouched.

// File: rtl/nlx_pkg.sv
package nlx_pkg;
  localparam int TABLE_W = 512;
  localparam int SLOT_W  = 32;
  localparam int IDX_W   = 4;
  localparam int ROWS    = 4;
  localparam int ROW_W   = $clog2(ROWS);
  localparam int REG_W   = 5;

  typedef struct packed {
    logic             load;
    logic             issue;
    logic [ROW_W-1:0] row;
  } nlx_strobe_t;
endpackage

// File: rtl/nlx_ctrl.sv
module nlx_ctrl
  import nlx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  sizeSel,
  output nlx_strobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        undefFlag
);
  typedef enum logic {S_IDLE, S_RUN} state_t;

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  state_t           state;
  logic [ROW_W-1:0] row;
  logic             accept;
  logic             sizeOk;

  assign accept = start && (state == S_IDLE);
  assign sizeOk = (sizeSel == 2'b00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      row       <= '0;
      done      <= 1'b0;
      undefFlag <= 1'b0;
    end else begin
      done      <= 1'b0;
      undefFlag <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            if (sizeOk) begin
              state <= S_RUN;
              row   <= '0;
            end else begin
              undefFlag <= 1'b1;
            end
          end
        end
        S_RUN: begin
          if (row == LAST_ROW) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            row <= row + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign strobe.load  = accept && sizeOk;
  assign strobe.issue = (state == S_RUN);
  assign strobe.row   = row;
  assign busy         = (state == S_RUN);
endmodule

// File: rtl/nlx_slot_pick.sv
module nlx_slot_pick
  import nlx_pkg::*;
#(
  parameter int ELEM_W = 8
) (
  input  logic [TABLE_W-1:0] tbl,
  input  logic [IDX_W-1:0]   sel,
  output logic [ELEM_W-1:0]  elem
);
  assign elem = tbl[int'(sel) * SLOT_W +: ELEM_W];
endmodule

// File: rtl/nlx_datapath.sv
module nlx_datapath
  import nlx_pkg::*;
#(
  parameter int VL     = 128,
  parameter int ELEM_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  nlx_strobe_t       strobe,
  input  logic [2*VL-1:0]   idxOperand,
  input  logic [TABLE_W-1:0] tableIn,
  input  logic              interleaved,
  input  logic [2:0]        grpSel,
  input  logic              bankSel,
  input  logic [1:0]        laneSel,
  output logic              wrEn,
  output logic [REG_W-1:0]  wrReg,
  output logic [VL-1:0]     wrData
);
  localparam int EL = VL / ELEM_W;

  logic [2*VL-1:0]    idxQ;
  logic [TABLE_W-1:0] tblQ;
  logic [REG_W-1:0]   baseQ;
  logic               strideQ;
  logic [REG_W-1:0]   offset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ    <= '0;
      tblQ    <= '0;
      baseQ   <= '0;
      strideQ <= 1'b0;
    end else if (strobe.load) begin
      idxQ    <= idxOperand;
      tblQ    <= tableIn;
      strideQ <= interleaved;
      baseQ   <= interleaved ? {bankSel, 2'b00, laneSel} : {grpSel, 2'b00};
    end
  end

  always_comb begin
    if (strideQ) offset = {1'b0, strobe.row, 2'b00};
    else         offset = {3'b000, strobe.row};
  end

  assign wrEn  = strobe.issue;
  assign wrReg = baseQ + offset;

  for (genvar e = 0; e < EL; e++) begin : g_lane
    logic [IDX_W-1:0] fld;
    assign fld = idxQ[(int'(strobe.row) * EL + e) * IDX_W +: IDX_W];
    nlx_slot_pick #(.ELEM_W(ELEM_W)) u_pick (
      .tbl  (tblQ),
      .sel  (fld),
      .elem (wrData[e*ELEM_W +: ELEM_W])
    );
  end
endmodule

// File: rtl/nibble_lut_expander.sv
module nibble_lut_expander
  import nlx_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         sizeSel,
  input  logic               interleaved,
  input  logic [2:0]         grpSel,
  input  logic               bankSel,
  input  logic [1:0]         laneSel,
  input  logic [3:0]         srcSel,
  input  logic [2*VL-1:0]    idxOperand,
  input  logic [511:0]       tableIn,
  output logic [4:0]         srcRegLo,
  output logic [4:0]         srcRegHi,
  output logic               busy,
  output logic               done,
  output logic               undefFlag,
  output logic               wrEn,
  output logic [4:0]         wrReg,
  output logic [VL-1:0]      wrData
);
  if ((VL % 128) != 0 || VL < 128 || VL > 2048) begin : g_bad_vl
    $error("VL must be a multiple of 128 between 128 and 2048");
  end

  nlx_strobe_t strobe;

  assign srcRegLo = {srcSel, 1'b0};
  assign srcRegHi = {srcSel, 1'b1};

  nlx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .sizeSel   (sizeSel),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done),
    .undefFlag (undefFlag)
  );

  nlx_datapath #(.VL(VL), .ELEM_W(8)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .idxOperand  (idxOperand),
    .tableIn     (tableIn),
    .interleaved (interleaved),
    .grpSel      (grpSel),
    .bankSel     (bankSel),
    .laneSel     (laneSel),
    .wrEn        (wrEn),
    .wrReg       (wrReg),
    .wrData      (wrData)
  );
endmodule

// File: rtl/nlx_checker.sv
module nlx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       undefFlag,
  input logic       wrEn,
  input logic [4:0] wrReg
);
  logic [2:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)     runLen <= '0;
    else if (wrEn) runLen <= (runLen == 3'd7) ? runLen : runLen + 3'd1;
    else           runLen <= '0;
  end

  // R3: a run never exceeds four writes
  p_run_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> runLen < 3'd4);

  // R3: the run that precedes done has exactly four writes
  p_four_writes_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> runLen == 3'd4);

  // R8: done follows the last write and is a single-cycle pulse
  p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wrEn) && !wrEn && !busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: undefined size never overlaps or triggers a write
  p_undef_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> !wrEn && !busy);

  p_undef_no_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |=> !wrEn);

  // R4 / R5: consecutive destinations step by one or by four
  p_reg_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn)) |->
      ((wrReg - $past(wrReg)) == 5'd1 || (wrReg - $past(wrReg)) == 5'd4));

  // R9: writes only while busy
  p_write_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);
endmodule

bind nibble_lut_expander nlx_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .undefFlag (undefFlag),
  .wrEn      (wrEn),
  .wrReg     (wrReg)
);

// File: tb/sim_nibble_lut_expander.sv
`timescale 1ns/1ps
module sim_nibble_lut_expander;
  localparam int VL = 128;
  localparam int EL = VL / 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      sizeSel = '0;
  logic            interleaved = 1'b0;
  logic [2:0]      grpSel = '0;
  logic            bankSel = 1'b0;
  logic [1:0]      laneSel = '0;
  logic [3:0]      srcSel = '0;
  logic [2*VL-1:0] idxOperand = '0;
  logic [511:0]    tableIn = '0;
  logic [4:0]      srcRegLo, srcRegHi, wrReg;
  logic            busy, done, undefFlag, wrEn;
  logic [VL-1:0]   wrData;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  nibble_lut_expander #(.VL(VL)) u0 (.*);

  typedef struct {
    logic [4:0]    r;
    logic [VL-1:0] d;
    bit            strided;
  } wr_t;

  wr_t q[$];
  wr_t cur;
  bit  curValid = 0;
  bit  expDone  = 0;
  bit  expUndef = 0;

  function automatic logic [VL-1:0] refRow(logic [2*VL-1:0] idx, logic [511:0] tbl, int r);
    logic [VL-1:0] res;
    for (int e = 0; e < EL; e++) begin
      int f;
      f = int'((idx >> ((r * EL + e) * 4)) & 4'hF);
      res[e*8 +: 8] = 8'((tbl >> (f * 32)) & 512'hFF);
    end
    return res;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      curValid = 0; expDone = 0; expUndef = 0;
    end else begin
      bit accept;
      bit lastEnd;
      accept  = start && !curValid;
      lastEnd = curValid && (q.size() == 0);
      if (curValid) begin
        if (q.size() > 0) cur = q.pop_front();
        else curValid = 0;
      end
      expDone  = lastEnd;
      expUndef = 0;
      if (accept) begin
        if (sizeSel != 2'b00) expUndef = 1;
        else begin
          for (int r = 0; r < 4; r++) begin
            wr_t w;
            w.strided = interleaved;
            w.r = interleaved ? 5'({bankSel, 2'b00, laneSel} + 4 * r)
                              : 5'({grpSel, 2'b00} + r);
            w.d = refRow(idxOperand, tableIn, r);
            if (r == 0) begin cur = w; curValid = 1; end
            else q.push_back(w);
          end
        end
      end
    end
  end

  task automatic chk(string req, logic [VL-1:0] act, logic [VL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      chk("R10 wrEn", VL'(wrEn), '0);
      chk("R10 busy", VL'(busy), '0);
      chk("R10 done", VL'(done), '0);
      chk("R10 undef", VL'(undefFlag), '0);
    end else begin
      chk("R3 wrEn", VL'(wrEn), VL'(curValid));
      chk("R9 busy", VL'(busy), VL'(curValid));
      chk("R8 done", VL'(done), VL'(expDone));
      chk("R7 undefFlag", VL'(undefFlag), VL'(expUndef));
      if (curValid && wrEn) begin
        chk(cur.strided ? "R5 wrReg" : "R4 wrReg", VL'(wrReg), VL'(cur.r));
        chk("R1 R2 wrData", wrData, cur.d);
      end
    end
  end

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [2*VL-1:0] rndIdx();
    logic [2*VL-1:0] v;
    for (int i = 0; i < 2*VL/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  // scramble: change operands and pulse start mid-run (R9)
  task automatic runOp(bit str, logic [2:0] g, bit b, logic [1:0] l,
                       logic [1:0] sz, logic [3:0] s,
                       logic [2*VL-1:0] idx, logic [511:0] tbl, bit scramble);
    step();
    interleaved = str; grpSel = g; bankSel = b; laneSel = l;
    sizeSel = sz; srcSel = s; idxOperand = idx; tableIn = tbl; start = 1'b1;
    #1;
    chk("R6 srcRegLo", VL'(srcRegLo), VL'({s, 1'b0}));
    chk("R6 srcRegHi", VL'(srcRegHi), VL'({s, 1'b1}));
    step();
    start = 1'b0;
    if (scramble) begin
      step();
      idxOperand = rndIdx(); tableIn = rnd512();
      interleaved = ~str; grpSel = ~g; start = 1'b1;
      step();
      start = 1'b0;
    end
    repeat (6) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [511:0]    tbl;
    logic [2*VL-1:0] idx;
    repeat (4) step();
    rstN = 1'b1;

    // R1: slots with noisy upper bits, ascending nibble stream
    for (int i = 0; i < 16; i++) tbl[i*32 +: 32] = {24'hA5C3E1, 8'(i * 17 + 3)};
    for (int i = 0; i < 2*VL/4; i++) idx[i*4 +: 4] = 4'(i);
    runOp(1'b0, 3'd0, 1'b0, 2'd0, 2'b00, 4'd0, idx, tbl, 1'b0);
    // R2: descending stream, upper half distinct
    for (int i = 0; i < 2*VL/4; i++) idx[i*4 +: 4] = 4'(15 - (i % 16) + (i / EL));
    runOp(1'b1, 3'd0, 1'b1, 2'd3, 2'b00, 4'd15, idx, tbl, 1'b0);

    // R4: every grouped destination base
    for (int g = 0; g < 8; g++)
      runOp(1'b0, 3'(g), 1'b0, 2'd0, 2'b00, 4'(g), rndIdx(), rnd512(), 1'b0);
    // R5: every interleaved base
    for (int b = 0; b < 2; b++)
      for (int l = 0; l < 4; l++)
        runOp(1'b1, 3'd0, 1'(b), 2'(l), 2'b00, 4'(b * 4 + l), rndIdx(), rnd512(), 1'b0);

    // R7: undefined sizes
    for (int sz = 1; sz < 4; sz++)
      runOp(1'($urandom), 3'($urandom), 1'b0, 2'd1, 2'(sz), 4'd7, rndIdx(), rnd512(), 1'b0);

    // R9: start and operand changes while busy
    for (int k = 0; k < 6; k++)
      runOp(1'(k), 3'(k), 1'(k), 2'(k), 2'b00, 4'(k), rndIdx(), rnd512(), 1'b1);

    // R8 / R3: start held high, second accept lands in the done cycle
    step();
    interleaved = 1'b1; bankSel = 1'b0; laneSel = 2'd2; sizeSel = 2'b00;
    idxOperand = rndIdx(); tableIn = rnd512(); start = 1'b1;
    repeat (12) step();
    start = 1'b0;
    repeat (8) step();

    // random mix in both patterns
    for (int k = 0; k < 30; k++)
      runOp(1'($urandom), 3'($urandom), 1'($urandom), 2'($urandom), 2'b00,
            4'($urandom), rndIdx(), rnd512(), 1'($urandom));

    // R10: reset mid-run
    runOp(1'b0, 3'd2, 1'b0, 2'd0, 2'b00, 4'd1, rndIdx(), rnd512(), 1'b0);
    step(); start = 1'b1; step(); start = 1'b0; step();
    rstN = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    repeat (3) step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule